// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces the horizontal sync, vertical sync and data-enable strobes of a video raster, together with the current pixel and line position. A pixel counter and a line counter run on the pixel clock and wrap at a frame extent that software programs. Each sync pulse is a span between a programmed first and last coordinate. The span may wrap across the counter boundary. The visible area is a rectangle given by two inclusive corners.

Software programs the block through a simple write port (address, data, strobe). Timing registers are staged and only take effect at a frame boundary, so a reconfiguration never tears a frame in progress. A run bit starts the raster from the origin or parks it. The porch arithmetic that turns a video mode into corner coordinates is left to software.

Top module: `raster_sync_gen`

## Requirements
- R1: During and right after a synchronous reset, pix_x and pix_y read 0 and hsync, vsync and de read 1, because all polarity bits reset to 0.
- R2: The run bit is bit 0 at address 0x00. While it is clear, pix_x and pix_y stay 0 and each strobe sits at its inactive level. The second cycle after the write that sets the bit shows position (0,0), and counting continues from there. The second cycle after the write that clears it is idle again.
- R3: The extent register at address 0x10 holds the last pixel index in bits [12:0]. pix_x advances by one each cycle and returns to 0 after that index.
- R4: The extent register holds the last line index in bits [28:16]. pix_y advances when pix_x wraps and returns to 0 after that index.
- R5: The hsync register at address 0x20 holds the first pixel in bits [12:0], the last pixel in bits [28:16] and the polarity in bit 31. The pulse is active for first <= x <= last when first <= last. When first > last, it is active for x >= first or x <= last.
- R6: The vsync register at address 0x30 uses the same layout and span rule as hsync, applied to the line index. It holds for every pixel of a selected line.
- R7: The window's upper-left corner is at address 0x40 (x in [12:0], y in [28:16], polarity in bit 31). The lower-right corner is at address 0x50 (same x/y fields). de is active when x and y each lie in their inclusive span, using the same wrap rule.
- R8: A polarity bit of 1 drives the strobe high when active. A polarity bit of 0 drives it low when active and high when inactive.
- R9: While running, writes to addresses 0x10 through 0x50 do not change the frame in progress. They take effect from the next (0,0).
- R10: Writes to any other address have no effect on any output.
- R11: The strobes shown in a cycle are the ones that belong to the pix_x and pix_y shown in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (8) | Register byte address |
| wr_data | input | DW (32) | Register write data |
| hsync | output | 1 | Horizontal sync, polarity as programmed |
| vsync | output | 1 | Vertical sync, polarity as programmed |
| de | output | 1 | Data enable, polarity as programmed |
| pix_x | output | 13 | Pixel index of the current output cycle |
| pix_y | output | 13 | Line index of the current output cycle |

## Verification
The counter and staging properties assume that the active frame extent never changes except at the wrap to the origin. The properties also assume the counters never sit beyond the extent, and this holds because the extent is loaded only while parked or at the wrap.

The stimulus keeps the bench's boundary model exact. It never writes timing registers while the raster is on its last line, so a write can never race the load at the frame boundary. Every random frame also has at least three lines. Idle strobe levels are compared only once a few cycles have passed since the last write or stop, which lets the staged polarity settle. The random cases put spans, corners and polarities anywhere in a small frame, including first > last and single-point spans.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int COORD_W = 13;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;

  localparam int FLD_X   = 0;
  localparam int FLD_Y   = 16;
  localparam int FLD_POL = 31;
  localparam int FLD_RUN = 0;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_EXTENT = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_HSYNC  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_VSYNC  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_WIN_UL = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_WIN_LR = 8'h50;

  typedef logic [COORD_W-1:0] coord_t;

  typedef struct packed {
    coord_t first;
    coord_t last;
    logic   pol;
  } pulse_t;

  typedef struct packed {
    coord_t last_x;
    coord_t last_y;
    pulse_t hs;
    pulse_t vs;
    coord_t ul_x;
    coord_t ul_y;
    coord_t lr_x;
    coord_t lr_y;
    logic   win_pol;
  } timing_t;

endpackage

// File: rtl/raster_span.sv
module raster_span
  import raster_pkg::*;
(
  input  coord_t pos,
  input  coord_t first,
  input  coord_t last,
  output logic   hit
);

  always_comb begin
    if (first <= last) hit = (pos >= first) && (pos <= last);
    else               hit = (pos >= first) || (pos <= last);
  end

endmodule

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          run,
  output timing_t       pend
);

  localparam logic [AW-1:0] A_CTRL   = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_EXTENT = AW'(OFS_EXTENT);
  localparam logic [AW-1:0] A_HSYNC  = AW'(OFS_HSYNC);
  localparam logic [AW-1:0] A_VSYNC  = AW'(OFS_VSYNC);
  localparam logic [AW-1:0] A_WIN_UL = AW'(OFS_WIN_UL);
  localparam logic [AW-1:0] A_WIN_LR = AW'(OFS_WIN_LR);

  coord_t fx, fy;
  logic   fpol;
  wire    unused_bits = ^wr_data;

  assign fx   = wr_data[FLD_X +: COORD_W];
  assign fy   = wr_data[FLD_Y +: COORD_W];
  assign fpol = wr_data[FLD_POL];

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      pend <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:   run <= wr_data[FLD_RUN];
        A_EXTENT: begin
          pend.last_x <= fx;
          pend.last_y <= fy;
        end
        A_HSYNC:  pend.hs <= '{first: fx, last: fy, pol: fpol};
        A_VSYNC:  pend.vs <= '{first: fx, last: fy, pol: fpol};
        A_WIN_UL: begin
          pend.ul_x    <= fx;
          pend.ul_y    <= fy;
          pend.win_pol <= fpol;
        end
        A_WIN_LR: begin
          pend.lr_x <= fx;
          pend.lr_y <= fy;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/raster_frame_ctr.sv
module raster_frame_ctr
  import raster_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    run,
  input  timing_t pend,
  output coord_t  cx,
  output coord_t  cy,
  output timing_t act
);

  logic end_of_line, end_of_frame;

  assign end_of_line  = (cx == act.last_x);
  assign end_of_frame = end_of_line && (cy == act.last_y);

  always_ff @(posedge clk) begin
    if (rst) begin
      cx  <= '0;
      cy  <= '0;
      act <= '0;
    end else if (!run) begin
      cx  <= '0;
      cy  <= '0;
      act <= pend;
    end else if (end_of_line) begin
      cx <= '0;
      if (end_of_frame) begin
        cy  <= '0;
        act <= pend;
      end else begin
        cy <= cy + 1'b1;
      end
    end else begin
      cx <= cx + 1'b1;
    end
  end

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import raster_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic [COORD_W-1:0] pix_x,
  output logic [COORD_W-1:0] pix_y
);

  localparam int NSPAN  = 4;
  localparam int SP_HS  = 0;
  localparam int SP_VS  = 1;
  localparam int SP_WX  = 2;
  localparam int SP_WY  = 3;

  logic    run;
  timing_t pend;
  timing_t act;
  coord_t  cx, cy;

  coord_t            sp_pos   [NSPAN];
  coord_t            sp_first [NSPAN];
  coord_t            sp_last  [NSPAN];
  logic [NSPAN-1:0]  sp_hit;

  raster_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .run     (run),
    .pend    (pend)
  );

  raster_frame_ctr u_ctr (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .pend (pend),
    .cx   (cx),
    .cy   (cy),
    .act  (act)
  );

  always_comb begin
    sp_pos[SP_HS]   = cx;       sp_first[SP_HS] = act.hs.first; sp_last[SP_HS] = act.hs.last;
    sp_pos[SP_VS]   = cy;       sp_first[SP_VS] = act.vs.first; sp_last[SP_VS] = act.vs.last;
    sp_pos[SP_WX]   = cx;       sp_first[SP_WX] = act.ul_x;     sp_last[SP_WX] = act.lr_x;
    sp_pos[SP_WY]   = cy;       sp_first[SP_WY] = act.ul_y;     sp_last[SP_WY] = act.lr_y;
  end

  for (genvar i = 0; i < NSPAN; i++) begin : g_span
    raster_span u_span (
      .pos   (sp_pos[i]),
      .first (sp_first[i]),
      .last  (sp_last[i]),
      .hit   (sp_hit[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_x <= '0;
      pix_y <= '0;
      hsync <= 1'b1;
      vsync <= 1'b1;
      de    <= 1'b1;
    end else if (!run) begin
      pix_x <= '0;
      pix_y <= '0;
      hsync <= ~act.hs.pol;
      vsync <= ~act.vs.pol;
      de    <= ~act.win_pol;
    end else begin
      pix_x <= cx;
      pix_y <= cy;
      hsync <= sp_hit[SP_HS] ~^ act.hs.pol;
      vsync <= sp_hit[SP_VS] ~^ act.vs.pol;
      de    <= (sp_hit[SP_WX] & sp_hit[SP_WY]) ~^ act.win_pol;
    end
  end

endmodule

// File: rtl/raster_sync_gen_chk.sv
module raster_sync_gen_chk
  import raster_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    run,
  input coord_t  cx,
  input coord_t  cy,
  input timing_t act,
  input logic    hsync,
  input coord_t  pix_x,
  input coord_t  pix_y
);

  AST_IDLE_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pix_x == '0 && pix_y == '0)); // R2

  AST_IDLE_HSYNC: assert property (@(posedge clk) disable iff (rst)
    !run |=> (hsync != $past(act.hs.pol))); // R8

  AST_X_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && cx != act.last_x) |=> (cx == $past(cx) + 1'b1)); // R3

  AST_X_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && cx == act.last_x) |=> (cx == '0)); // R3

  AST_Y_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run && cx != act.last_x) |=> $stable(cy)); // R4

  AST_FRAME_STABLE: assert property (@(posedge clk) disable iff (rst)
    (run && !(cx == act.last_x && cy == act.last_y)) |=> $stable(act)); // R9

endmodule

bind raster_sync_gen raster_sync_gen_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .run   (run),
  .cx    (cx),
  .cy    (cy),
  .act   (act),
  .hsync (hsync),
  .pix_x (pix_x),
  .pix_y (pix_y)
);

// File: tb/raster_sync_gen_tb_top.sv
module raster_sync_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hsync, vsync, de;
  logic [12:0] pix_x, pix_y;

  always #10 clk = ~clk;

  raster_sync_gen dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y)
  );

  typedef struct {
    int lx, ly;
    int hf, hl, hp;
    int vf, vl, vp;
    int ux, uy, rx, ry, wp;
  } cfg_s;

  cfg_s pc, fc;
  bit   live = 0, mrun = 0;
  int   start_cd = 0, stop_cd = 0, age = 100, since_wr = 100;
  int   ex = 0, ey = 0;
  int   nvec = 0, nerr = 0;
  bit   done = 0;

  function automatic bit span(int c, int f, int l);
    if (f <= l) return (c >= f) && (c <= l);
    return (c >= f) || (c <= l);
  endfunction

  function automatic bit lvl(bit act, int pol);
    return (pol != 0) ? act : !act;
  endfunction

  function automatic logic [31:0] mk(int x, int y, int pol);
    logic [31:0] w;
    w = '0;
    w[12:0]  = 13'(x);
    w[28:16] = 13'(y);
    w[31]    = pol[0];
    return w;
  endfunction

  task automatic chk(string tag, int got, int exp);
    nvec++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d (x=%0d y=%0d)", tag, got, exp, ex, ey);
    end
  endtask

  task automatic model_write(logic [7:0] a, logic [31:0] d);
    int x, y, p;
    x = int'(d[12:0]); y = int'(d[28:16]); p = int'(d[31]);
    case (a)
      8'h00: begin
        if (d[0] && !mrun) start_cd = 2;
        else if (!d[0] && mrun) stop_cd = 2;
        mrun = d[0];
      end
      8'h10: begin pc.lx = x; pc.ly = y; since_wr = 0; end
      8'h20: begin pc.hf = x; pc.hl = y; pc.hp = p; since_wr = 0; end
      8'h30: begin pc.vf = x; pc.vl = y; pc.vp = p; since_wr = 0; end
      8'h40: begin pc.ux = x; pc.uy = y; pc.wp = p; since_wr = 0; end
      8'h50: begin pc.rx = x; pc.ry = y; since_wr = 0; end
      default: ; // R10: other addresses leave the model untouched
    endcase
  endtask

  task automatic tick(bit we, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    if (start_cd > 0) begin
      start_cd--;
      if (start_cd == 0) begin live = 1; ex = 0; ey = 0; fc = pc; end
    end
    if (stop_cd > 0) begin
      stop_cd--;
      if (stop_cd == 0) begin live = 0; age = 0; end
    end
    if (live) begin
      chk("R3/R2/R11 pix_x", int'(pix_x), ex);
      chk("R4/R11 pix_y", int'(pix_y), ey);
      chk("R5/R8/R9/R10 hsync", int'(hsync), int'(lvl(span(ex, fc.hf, fc.hl), fc.hp)));
      chk("R6/R8/R9 vsync", int'(vsync), int'(lvl(span(ey, fc.vf, fc.vl), fc.vp)));
      chk("R7/R8/R9 de", int'(de),
          int'(lvl(span(ex, fc.ux, fc.rx) && span(ey, fc.uy, fc.ry), fc.wp)));
      if (ex == fc.lx) begin
        ex = 0;
        if (ey == fc.ly) begin ey = 0; fc = pc; end
        else ey++;
      end else ex++;
    end else begin
      chk("R2 idle pix_x", int'(pix_x), 0);
      chk("R2 idle pix_y", int'(pix_y), 0);
      if (age >= 3 && since_wr >= 3) begin
        chk("R2/R8 idle hsync", int'(hsync), int'(pc.hp == 0));
        chk("R2/R8 idle vsync", int'(vsync), int'(pc.vp == 0));
        chk("R2/R8 idle de", int'(de), int'(pc.wp == 0));
      end
      age++;
    end
    since_wr++;
    wr_en = we; wr_addr = a; wr_data = d;
    if (we) model_write(a, d);
  endtask

  task automatic idle_ticks(int n);
    for (int i = 0; i < n; i++) tick(0, 8'h00, '0);
  endtask

  task automatic rnd_reg_write();
    int sel;
    int lim;
    lim = 24;
    sel = int'($urandom_range(6, 0));
    case (sel)
      0: tick(1, 8'h10, mk(int'($urandom_range(20, 3)), int'($urandom_range(7, 2)), 0));
      1: tick(1, 8'h20, mk(int'($urandom_range(lim, 0)), int'($urandom_range(lim, 0)), int'($urandom_range(1, 0))));
      2: tick(1, 8'h30, mk(int'($urandom_range(8, 0)), int'($urandom_range(8, 0)), int'($urandom_range(1, 0))));
      3: tick(1, 8'h40, mk(int'($urandom_range(lim, 0)), int'($urandom_range(8, 0)), int'($urandom_range(1, 0))));
      4: tick(1, 8'h50, mk(int'($urandom_range(lim, 0)), int'($urandom_range(8, 0)), 0));
      5: tick(1, 8'h70, $urandom()); // R10 unmapped
      default: tick(1, 8'h24, $urandom()); // R10 unmapped
    endcase
  endtask

  task automatic rnd_config();
    tick(1, 8'h10, mk(int'($urandom_range(20, 3)), int'($urandom_range(7, 2)), 0));
    tick(1, 8'h20, mk(int'($urandom_range(22, 0)), int'($urandom_range(22, 0)), int'($urandom_range(1, 0))));
    tick(1, 8'h30, mk(int'($urandom_range(8, 0)), int'($urandom_range(8, 0)), int'($urandom_range(1, 0))));
    tick(1, 8'h40, mk(int'($urandom_range(22, 0)), int'($urandom_range(8, 0)), int'($urandom_range(1, 0))));
    tick(1, 8'h50, mk(int'($urandom_range(22, 0)), int'($urandom_range(8, 0)), 0));
  endtask

  task automatic run_mixed(int n);
    for (int i = 0; i < n; i++) begin
      if (live && start_cd == 0 && stop_cd == 0 && ey < fc.ly && $urandom_range(11, 0) == 0)
        rnd_reg_write();
      else
        tick(0, 8'h00, '0);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F3A_5EED));
    pc = '{default: 0};
    fc = pc;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pix_x", int'(pix_x), 0);
    chk("R1 pix_y", int'(pix_y), 0);
    chk("R1 hsync", int'(hsync), 1);
    chk("R1 vsync", int'(vsync), 1);
    chk("R1 de", int'(de), 1);
    rst = 1'b0;

    // Directed frame: 10 x 4, hsync wrapping through x=0, single-line vsync
    tick(1, 8'h10, mk(9, 3, 0));
    tick(1, 8'h20, mk(9, 1, 1));
    tick(1, 8'h30, mk(1, 1, 0));
    tick(1, 8'h40, mk(2, 1, 1));
    tick(1, 8'h50, mk(7, 2, 0));
    idle_ticks(6);
    tick(1, 8'h00, 32'h1);
    idle_ticks(90);
    // R9: change hsync mid-frame on line 1; the current frame must keep the old one
    while (!(live && ey == 1)) tick(0, 8'h00, '0);
    tick(1, 8'h20, mk(3, 5, 0));
    tick(1, 8'h70, 32'hFFFF_FFFF); // R10
    tick(1, 8'h04, 32'hFFFF_FFFF); // R10
    idle_ticks(90);
    // R7: window wrapping in x, and a single-point hsync
    while (!(live && ey == 0)) tick(0, 8'h00, '0);
    tick(1, 8'h40, mk(8, 2, 1));
    tick(1, 8'h50, mk(1, 3, 0));
    tick(1, 8'h20, mk(4, 4, 1));
    idle_ticks(100);
    tick(1, 8'h00, 32'h0);
    idle_ticks(8);

    for (int it = 0; it < 30; it++) begin
      rnd_config();
      idle_ticks(int'($urandom_range(6, 1)));
      tick(1, 8'h00, 32'h1);
      run_mixed(int'($urandom_range(260, 60)));
      tick(1, 8'h00, 32'h0);
      idle_ticks(6);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule